// File: doc/BRIEF.md
# SPI Banked Status Readback Unit

This block is the serial readback path of a two-channel power-switch controller. A host talks to it over a four-wire SPI link in 16-bit frames. Each frame can carry a status-select command that names one register: one of five per-channel registers in bank 0 or bank 1, or one of three registers shared by both banks. The contents of that register are not returned in the same frame. They come back in the next frame, inside a 16-bit response word.

The response word also carries the watchdog toggle bit of the last accepted word and an error flag for the previous frame. It echoes the current bank and register code and reports whether the device is in normal mode. A frame that has the wrong length or fails the odd-parity check is rejected. In that case the unit keeps returning the register that was last addressed successfully.

The SPI pins are brought into the system clock domain through a synchronizer. The register contents are plain input ports, captured when a frame begins. A frame tracker has three states: IDLE, XFER and OVER. On a chip-select falling edge, IDLE goes to XFER. On a seventeenth SCLK rising edge, XFER goes to OVER. On a chip-select rising edge, both XFER and OVER return to IDLE, and the frame is committed or rejected at that point.

Top module: `spi_status_readback`

## Requirements
- R1: A frame is accepted only when chip-select stays low for exactly 16 SCLK rising edges and the 16 received bits hold an odd number of ones. Acceptance or rejection is decided when chip-select rises.
- R2: The response word is captured when chip-select falls. It is driven on SO MSB first, advancing one bit after each SCLK falling edge. SO is 0 while no frame is in progress.
- R3: Response bit 15 equals bit 15 of the last accepted word. A rejected frame leaves it unchanged.
- R4: Response bit 14 is 1 exactly when the previous frame was rejected, for either bad parity or wrong length.
- R5: Response bits 13..10 are {bank, code} of the current selection. A status-select word is an accepted word whose bits 12..10 are 000. Such a word loads the bank from its bit 13 and the code from its bits 2..0.
- R6: Response bit 9 equals the normal_mode input.
- R7: Response bits 8..0 hold the selected register. Codes 1 to 5 pick fault, PWM, configuration, over-current and retry from the selected bank; these are entries 0 to 4 of that bank's input array. Codes 0, 6 and 7 pick the shared status, global-configuration and diagnostics registers in either bank.
- R8: A rejected frame leaves the selection unchanged, so the next response returns the last successfully addressed register.
- R9: An accepted word whose bits 12..10 are not 000 leaves the selection unchanged. It still updates the watchdog bit and clears the error flag.
- R10: After reset the selection is bank 0, code 0 (status). The watchdog bit and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in, sampled on SCLK rise |
| spi_miso | output | 1 | Serial response out, MSB first |
| normal_mode | input | 1 | Device is in normal mode |
| bank0_regs | input | 5x9 | Bank 0 per-channel registers |
| bank1_regs | input | 5x9 | Bank 1 per-channel registers |
| status_reg | input | 9 | Shared status register |
| gconf_reg | input | 9 | Shared global-configuration register |
| diag_reg | input | 9 | Shared diagnostics register |

## Verification
Every register input carries a distinct value, so a wrong bank or a wrong code shows up directly in the data field. Selection words walk through both banks and through per-channel and shared codes. Each response is compared one frame later, which separates a missing one-frame delay from a wrong decode. Frames with bad parity, with 15 bits and with 17 bits are placed between good selections; they show that rejection holds the old register and raises only the error flag. A valid word with a non-select command shows that the watchdog bit updates while the selection stays put.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int WORD_W      = 16;
    localparam int DATA_W      = 9;
    localparam int CODE_W      = 3;
    localparam int NUM_CH_REGS = 5;
    localparam int CNT_W       = $clog2(WORD_W + 1);

    // field positions inside a received word
    localparam int POS_WD      = 15;
    localparam int POS_BANK    = 13;
    localparam int CMD_HI      = 12;
    localparam int CMD_LO      = 10;
    localparam logic [CMD_HI-CMD_LO:0] CMD_SELECT = '0;

    // per-channel register slots in a bank input array
    localparam int IDX_FAULT = 0;
    localparam int IDX_PWM   = 1;
    localparam int IDX_CONF  = 2;
    localparam int IDX_OCUR  = 3;
    localparam int IDX_RETRY = 4;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_XFER = 2'd1,
        FR_OVER = 2'd2
    } frame_state_e;

    typedef enum logic [CODE_W-1:0] {
        RC_STATUS = 3'd0,
        RC_FAULT  = 3'd1,
        RC_PWM    = 3'd2,
        RC_CONF   = 3'd3,
        RC_OCUR   = 3'd4,
        RC_RETRY  = 3'd5,
        RC_GCONF  = 3'd6,
        RC_DIAG   = 3'd7
    } reg_code_e;

    typedef struct packed {
        logic              bank;
        logic [CODE_W-1:0] code;
    } sel_t;

    function automatic logic parity_is_odd(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b010; // {mosi, cs_n, sclk}

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_prev_q;
    logic            cs_prev_q;

    assign raw = {mosi_i, cs_n_i, sclk_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= synced[0];
            cs_prev_q   <= synced[1];
        end
    end

    assign sclk_rise = synced[0] & ~sclk_prev_q;
    assign sclk_fall = ~synced[0] & sclk_prev_q;
    assign cs_fall   = ~synced[1] & cs_prev_q;
    assign cs_rise   = synced[1] & ~cs_prev_q;
    assign mosi_s    = synced[2];

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              mosi_s,
    output logic              frame_start,
    output logic              frame_done,
    output logic              frame_ok,
    output logic [WORD_W-1:0] rx_word
);
    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] shreg_q, shreg_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shreg_d = shreg_q;
        unique case (state_q)
            FR_IDLE: begin
                if (cs_fall) begin
                    state_d = FR_XFER;
                    cnt_d   = '0;
                end
            end
            FR_XFER: begin
                if (cs_rise) begin
                    state_d = FR_IDLE;
                end else if (sclk_rise) begin
                    if (cnt_q == CNT_W'(WORD_W)) begin
                        state_d = FR_OVER;
                    end else begin
                        shreg_d = {shreg_q[WORD_W-2:0], mosi_s};
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            FR_OVER: begin
                if (cs_rise) state_d = FR_IDLE;
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_start = cs_fall && (state_q == FR_IDLE);
        frame_done  = cs_rise && (state_q != FR_IDLE);
        frame_ok    = (state_q == FR_XFER) && (cnt_q == CNT_W'(WORD_W))
                      && parity_is_odd(shreg_q);
        rx_word     = shreg_q;
    end

    assert_overrun_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_XFER && !cs_rise && sclk_rise && cnt_q == CNT_W'(WORD_W))
        |=> state_q == FR_OVER);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WORD_W));

    assert_commit_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> state_q == FR_IDLE);

    assert_over_never_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_OVER) |-> !frame_ok);

endmodule

// File: rtl/spi_rb_regsel.sv
module spi_rb_regsel
    import spi_rb_pkg::*;
#(
    parameter int NREG  = NUM_CH_REGS,
    parameter int DW    = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_done,
    input  logic                      frame_ok,
    input  logic [WORD_W-1:0]         rx_word,
    input  logic [NREG-1:0][DW-1:0]   bank0_regs,
    input  logic [NREG-1:0][DW-1:0]   bank1_regs,
    input  logic [DW-1:0]             status_reg,
    input  logic [DW-1:0]             gconf_reg,
    input  logic [DW-1:0]             diag_reg,
    output sel_t                      sel_q,
    output logic                      wd_q,
    output logic                      err_q,
    output logic [DW-1:0]             sel_data
);
    logic                    is_select;
    logic [NREG-1:0][DW-1:0] chan_bank;
    logic                    unused_rx_bits;

    assign is_select      = (rx_word[CMD_HI:CMD_LO] == CMD_SELECT);
    assign unused_rx_bits = ^rx_word[CMD_LO-1:CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            wd_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (frame_done) begin
            if (frame_ok) begin
                wd_q  <= rx_word[POS_WD];
                err_q <= 1'b0;
                if (is_select) begin
                    sel_q.bank <= rx_word[POS_BANK];
                    sel_q.code <= rx_word[CODE_W-1:0];
                end
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign chan_bank = sel_q.bank ? bank1_regs : bank0_regs;

    always_comb begin
        sel_data = '0;
        unique case (reg_code_e'(sel_q.code))
            RC_STATUS: sel_data = status_reg;
            RC_FAULT:  sel_data = chan_bank[IDX_FAULT];
            RC_PWM:    sel_data = chan_bank[IDX_PWM];
            RC_CONF:   sel_data = chan_bank[IDX_CONF];
            RC_OCUR:   sel_data = chan_bank[IDX_OCUR];
            RC_RETRY:  sel_data = chan_bank[IDX_RETRY];
            RC_GCONF:  sel_data = gconf_reg;
            RC_DIAG:   sel_data = diag_reg;
            default:   sel_data = '0;
        endcase
    end

    assert_reject_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_ok) |=> ($stable(sel_q) && $stable(wd_q) && err_q));

    assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_ok) |=> !err_q);

    assert_sel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(sel_q));

    assert_other_cmd_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_ok && !is_select) |=> $stable(sel_q));

endmodule

// File: rtl/spi_rb_txword.sv
module spi_rb_txword
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic [WORD_W-1:0] word_in,
    output logic              miso
);
    logic [WORD_W-1:0] tx_sr_q;
    logic              active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q  <= '0;
            active_q <= 1'b0;
        end else begin
            if (frame_start) begin
                tx_sr_q  <= word_in;
                active_q <= 1'b1;
            end else begin
                if (cs_rise) active_q <= 1'b0;
                if (active_q && sclk_fall) tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign miso = active_q & tx_sr_q[WORD_W-1];

    assert_capture_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tx_sr_q == $past(word_in)) && active_q);

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && sclk_fall && !frame_start)
        |=> tx_sr_q[WORD_W-1:1] == $past(tx_sr_q[WORD_W-2:0]));

    assert_quiet_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !frame_start) |=> !miso);

endmodule

// File: rtl/spi_status_readback.sv
module spi_status_readback
    import spi_rb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NREG        = NUM_CH_REGS,
    parameter int DW          = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    input  logic                    normal_mode,
    input  logic [NREG-1:0][DW-1:0] bank0_regs,
    input  logic [NREG-1:0][DW-1:0] bank1_regs,
    input  logic [DW-1:0]           status_reg,
    input  logic [DW-1:0]           gconf_reg,
    input  logic [DW-1:0]           diag_reg
);
    logic              sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
    logic              frame_start, frame_done, frame_ok;
    logic [WORD_W-1:0] rx_word;
    sel_t              sel_q;
    logic              wd_q, err_q;
    logic [DW-1:0]     sel_data;
    logic [WORD_W-1:0] resp_word;

    spi_rb_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s)
    );

    spi_rb_frame i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .mosi_s      (mosi_s),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .frame_ok    (frame_ok),
        .rx_word     (rx_word)
    );

    spi_rb_regsel #(.NREG(NREG), .DW(DW)) i_regsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_ok   (frame_ok),
        .rx_word    (rx_word),
        .bank0_regs (bank0_regs),
        .bank1_regs (bank1_regs),
        .status_reg (status_reg),
        .gconf_reg  (gconf_reg),
        .diag_reg   (diag_reg),
        .sel_q      (sel_q),
        .wd_q       (wd_q),
        .err_q      (err_q),
        .sel_data   (sel_data)
    );

    assign resp_word = {wd_q, err_q, sel_q, normal_mode, sel_data};

    spi_rb_txword i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cs_rise     (cs_rise),
        .sclk_fall   (sclk_fall),
        .word_in     (resp_word),
        .miso        (spi_miso)
    );

    assert_start_done_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_done));

endmodule

// File: tb/test_spi_status_readback.sv
module test_spi_status_readback;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic nm = 1'b1;
    logic [4:0][8:0] b0, b1;
    logic [8:0] st_r, gc_r, dg_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    spi_status_readback i_spi_status_readback (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .normal_mode(nm),
        .bank0_regs (b0),
        .bank1_regs (b1),
        .status_reg (st_r),
        .gconf_reg  (gc_r),
        .diag_reg   (dg_r)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [4:0]  nbits;
        logic        bad_par;
        logic [15:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{16'h8001, 5'd16, 1'b0, 16'h02A5, "R10"}, // reset selection
        '{16'h2003, 5'd16, 1'b0, 16'h8701, "R3 "}, // wd from 0x8001, bank0 fault
        '{16'h8006, 5'd16, 1'b0, 16'h2F13, "R5 "}, // bank1 config echoed
        '{16'h0007, 5'd16, 1'b1, 16'h9A5A, "R7 "}, // global config, bad parity sent
        '{16'h2004, 5'd16, 1'b0, 16'hDA5A, "R4 "}, // flag after bad parity, held sel
        '{16'h8000, 5'd15, 1'b0, 16'h3314, "R8 "}, // bank1 over-current, short frame sent
        '{16'h0405, 5'd16, 1'b0, 16'h7314, "R1 "}, // short frame rejected
        '{16'h2002, 5'd17, 1'b0, 16'h3314, "R9 "}, // other command kept selection
        '{16'h2007, 5'd16, 1'b0, 16'h7314, "R8 "}, // long frame rejected, held
        '{16'h8000, 5'd16, 1'b0, 16'h3FC3, "R7 "}, // diag via bank1
        '{16'h2000, 5'd16, 1'b0, 16'h82A5, "R3 "}, // wd=1, status
        '{16'h0000, 5'd16, 1'b0, 16'h22A5, "R7 "}  // status via bank1
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_frame(input logic [15:0] w, input int nbits, output logic [15:0] rx);
        rx = '0;
        sclk = 1'b0;
        cs_n = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            tick(6);
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            tick(6);
            sclk = 1'b0;
        end
        tick(6);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(10);
    endtask

    function automatic logic [15:0] fix_parity(input logic [15:0] w, input logic bad);
        logic [15:0] r = w;
        if ((^r) == bad) r[8] = ~r[8];
        return r;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input logic [15:0] mask, input logic [23:0] tag);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act & mask, exp & mask);
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            b0[i] = 9'h101 + 9'(i);
            b1[i] = 9'h111 + 9'(i);
        end
        st_r = 9'h0A5;
        gc_r = 9'h05A;
        dg_r = 9'h1C3;
    end

    initial begin
        logic [15:0] rx;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R2: SO quiet with no frame in progress after reset
        check({15'd0, miso}, 16'h0000, 16'hFFFF, "R2 ");

        for (int v = 0; v < NVEC; v++) begin
            spi_frame(fix_parity(VECS[v].word, VECS[v].bad_par), int'(VECS[v].nbits), rx);
            if (VECS[v].nbits < 5'd16)
                check(rx, VECS[v].exp, 16'hFFFF << (16 - int'(VECS[v].nbits)), VECS[v].tag);
            else
                check(rx, VECS[v].exp, 16'hFFFF, VECS[v].tag);
        end

        // R6: normal-mode flag follows its input (selection bank0 status, wd 0)
        nm = 1'b0;
        spi_frame(fix_parity(16'h0000, 1'b0), 16, rx);
        check(rx, 16'h00A5, 16'hFFFF, "R6 ");

        // R7: register contents taken fresh at frame start
        nm = 1'b1;
        st_r = 9'h0F0;
        spi_frame(fix_parity(16'h0000, 1'b0), 16, rx);
        check(rx, 16'h02F0, 16'hFFFF, "R7 ");

        // R2: SO returns low once chip-select is high
        check({15'd0, miso}, 16'h0000, 16'hFFFF, "R2 ");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule